// File: doc/BRIEF.md
# CAN Interrupt Pending and Code Unit

This block keeps the interrupt pending flags of a CAN controller. There is one flag for error events and one flag for each of fifteen message buffers. The error logic and the buffers raise their flags with single-cycle set pulses. Software lowers a flag by writing a one to the matching bit of a write-only clear register. A read/write enable mask chooses which pending flags take part in the interrupt code.

Every cycle the block finds the highest-priority flag that is both pending and enabled, and registers the result as an IRQ bit and a 4-bit source code. A read-only status register returns that code together with the 3-bit node status supplied by the error management logic. The registered IRQ bit also drives the interrupt request output.

The block has no state machine. Its only sequential state is the pending vector, the enable mask and the registered code.

Top module: `can_irq_unit`

## Requirements
- R1: After reset all pending flags and all enable bits are 0, status reads IRQ=0 and code 0000, and `irq_o` is 0.
- R2: Writing address 0 (clear register) with bit 15 set clears the error flag, and with bit n set (n=0..14) clears the flag of buffer n. Any 0 bit leaves its flag unchanged.
- R3: The clear register is write-only and address 0 reads 0x0000. Address 3 also reads 0x0000.
- R4: Address 1 is the enable mask and reads back what was written. Bit 15 enables the error source and bit n enables buffer n.
- R5: A pending flag whose enable bit is 0 does not appear in IRQ or the code, and it stays pending until cleared.
- R6: A pending, enabled error gives IRQ=1 and code 0000. This holds even when buffers are also pending and enabled.
- R7: A pending, enabled buffer n with no enabled error gives IRQ=1 and code n+1, so buffer 14 gives 1111. Among several buffers the lowest-numbered one is reported.
- R8: When no source is both pending and enabled, IRQ=0 and the code is 0000.
- R9: If a set pulse and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R10: Address 2 (status) reads bits 15:8 as 0, bits 7:5 as `node_state`, bit 4 as IRQ and bits 3:0 as the code. The node status codes are: 000 not active, 010 error active, 011 warning level, 10x error passive, 11x bus off. Writes to address 2 change nothing.
- R11: `irq_o` equals the status IRQ bit. The code is registered, so it follows a change in the pending flags or the enables one clock later; after a set pulse it shows on the second rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 2 | Register address: 0 clear, 1 enable, 2 status |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| err_set | input | 1 | Set pulse for the error flag |
| buf_set | input | 15 | Set pulses, one per message buffer |
| node_state | input | 3 | Node status from the error management logic |
| irq_o | output | 1 | Interrupt request, the registered IRQ bit |

## Verification
A flag that is stuck or lost can only be seen through the code, and only when its enable bit is on. The bench therefore reads each source under its own enable, and again under a full mask. A wrong priority or a wrong code offset shows as a wrong status value one cycle after the enable write. A clear that misses its bit, or a set that loses to a clear, leaves a stale or missing code that shows on the next status read. A misrouted node status or reserved bit shows at once on a read of address 2.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
    localparam int DATA_W  = 16;
    localparam int NUM_BUF = 15;
    localparam int SRC_N   = NUM_BUF + 1;
    localparam int ERR_BIT = DATA_W - 1;
    localparam int CODE_W  = $clog2(NUM_BUF + 1);
    localparam int NS_W    = 3;

    typedef enum logic [1:0] {
        REG_CLEAR  = 2'd0,
        REG_ENABLE = 2'd1,
        REG_STATUS = 2'd2,
        REG_SPARE  = 2'd3
    } reg_sel_e;

    // Field placement in the status word.
    localparam int ST_CODE_LSB = 0;
    localparam int ST_IRQ_BIT  = CODE_W;
    localparam int ST_NS_LSB   = CODE_W + 1;
endpackage

// File: rtl/can_irq_flags.sv
module can_irq_flags
    import can_irq_pkg::*;
#(
    parameter int N = SRC_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] pend
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                pend[g] <= 1'b0;
            else if (set_vec[g])
                pend[g] <= 1'b1;
            else if (clr_vec[g])
                pend[g] <= 1'b0;
        end
    end

    // R9: a set pulse is never lost, even against a clear
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((pend & $past(set_vec)) == $past(set_vec)));

    // R2: a write-one clear without a set leaves the flag low
    p_clear_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_vec & ~set_vec)) |=> ((pend & $past(clr_vec & ~set_vec)) == '0));
endmodule

// File: rtl/can_irq_regs.sv
module can_irq_regs
    import can_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    input  logic [NS_W-1:0]   node_state,
    input  logic              irq_q,
    input  logic [CODE_W-1:0] code_q,
    output logic [DATA_W-1:0] en_mask,
    output logic [DATA_W-1:0] clr_pulse,
    output logic [DATA_W-1:0] rdata
);
    reg_sel_e sel;
    logic [DATA_W-1:0] status_word;

    assign sel = reg_sel_e'(addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            en_mask <= '0;
        else if (we && sel == REG_ENABLE)
            en_mask <= wdata;
    end

    // The clear register holds no state: its write only yields a pulse.
    assign clr_pulse = (we && sel == REG_CLEAR) ? wdata : '0;

    always_comb begin
        status_word = '0;
        status_word[ST_CODE_LSB +: CODE_W] = code_q;
        status_word[ST_IRQ_BIT]            = irq_q;
        status_word[ST_NS_LSB +: NS_W]     = node_state;
    end

    always_comb begin
        unique case (sel)
            REG_ENABLE: rdata = en_mask;
            REG_STATUS: rdata = status_word;
            REG_CLEAR,
            REG_SPARE:  rdata = '0;
            default:    rdata = '0;
        endcase
    end

    // R4: an enable write is held exactly
    p_en_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == 2'd1) |=> (en_mask == $past(wdata)));

    // R10: only an enable write changes the mask
    p_en_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && addr == 2'd1) |=> $stable(en_mask));
endmodule

// File: rtl/can_irq_prio.sv
module can_irq_prio
    import can_irq_pkg::*;
#(
    parameter int NB = NUM_BUF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_hit,
    input  logic [NB-1:0]     buf_hit,
    output logic              irq_q,
    output logic [CODE_W-1:0] code_q
);
    logic              irq_d;
    logic [CODE_W-1:0] code_d;

    always_comb begin
        code_d = '0;
        for (int i = NB - 1; i >= 0; i--) begin
            if (buf_hit[i])
                code_d = CODE_W'(i + 1);
        end
        if (err_hit)
            code_d = '0;
        irq_d = err_hit | (|buf_hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q  <= 1'b0;
            code_q <= '0;
        end else begin
            irq_q  <= irq_d;
            code_q <= code_d;
        end
    end

    // R8: nothing enabled and pending gives an all-zero code
    p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_hit || (|buf_hit)) |=> (!irq_q && code_q == '0));

    // R6: the error outranks every buffer
    p_err_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_hit |=> (irq_q && code_q == '0));

    // R7: buffer 0 alone at the top gives code 1
    p_buf0_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_hit && buf_hit[0]) |=> (irq_q && code_q == CODE_W'(1)));
endmodule

// File: rtl/can_irq_unit.sv
module can_irq_unit
    import can_irq_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   bus_addr,
    input  logic [15:0]  bus_wdata,
    input  logic         bus_we,
    output logic [15:0]  bus_rdata,
    input  logic         err_set,
    input  logic [14:0]  buf_set,
    input  logic [2:0]   node_state,
    output logic         irq_o
);
    logic [DATA_W-1:0] en_mask;
    logic [DATA_W-1:0] clr_pulse;
    logic [SRC_N-1:0]  set_vec;
    logic [SRC_N-1:0]  pend;
    logic [SRC_N-1:0]  hit;
    logic              irq_q;
    logic [CODE_W-1:0] code_q;

    // Bit ERR_BIT of every vector is the error source, bits below are buffers.
    assign set_vec = {err_set, buf_set};
    assign hit     = pend & en_mask;

    can_irq_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .we         (bus_we),
        .node_state (node_state),
        .irq_q      (irq_q),
        .code_q     (code_q),
        .en_mask    (en_mask),
        .clr_pulse  (clr_pulse),
        .rdata      (bus_rdata)
    );

    can_irq_flags #(.N(SRC_N)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_pulse),
        .pend    (pend)
    );

    can_irq_prio #(.NB(NUM_BUF)) u_prio (
        .clk     (clk),
        .rst_n   (rst_n),
        .err_hit (hit[ERR_BIT]),
        .buf_hit (hit[NUM_BUF-1:0]),
        .irq_q   (irq_q),
        .code_q  (code_q)
    );

    assign irq_o = irq_q;

    // R11: the request output follows the registered pending-and-enabled state
    p_irq_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> irq_o);

    // R5: with an empty mask no request can rise
    p_mask_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_mask == '0) |=> !irq_o);
endmodule

// File: tb/tb_can_irq_unit.sv
module tb_can_irq_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_rdata;
    logic        err_set = 1'b0;
    logic [14:0] buf_set = '0;
    logic [2:0]  node_state = '0;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    can_irq_unit dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .err_set(err_set),
        .buf_set(buf_set), .node_state(node_state), .irq_o(irq_o)
    );

    task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic pulse(logic e, logic [14:0] b);
        @(negedge clk);
        err_set = e; buf_set = b;
        @(negedge clk);
        err_set = 1'b0; buf_set = '0;
    endtask

    task automatic settle();
        @(negedge clk);
        @(negedge clk);
    endtask

    function automatic logic [15:0] status_exp(logic [2:0] ns, logic irq, logic [3:0] code);
        return {8'h00, ns, irq, code};
    endfunction

    task automatic rd_status(output logic [15:0] v);
        @(negedge clk);
        bus_addr = 2'd2;
        #1 v = bus_rdata;
    endtask

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_status(v);
        check("R1 status", v, 16'h0000);
        check("R1 irq", {15'h0, irq_o}, 16'h0);
        bus_addr = 2'd1; #1 check("R1 enable", bus_rdata, 16'h0000);

        // R4 enable readback, R3 clear and spare read 0
        wr(2'd1, 16'hA5C3);
        bus_addr = 2'd1; #1 check("R4 enable rb", bus_rdata, 16'hA5C3);
        bus_addr = 2'd0; #1 check("R3 clear reads 0", bus_rdata, 16'h0000);
        bus_addr = 2'd3; #1 check("R3 spare reads 0", bus_rdata, 16'h0000);
        wr(2'd1, 16'h0000);

        // R10 node status sweep and reserved bits
        for (int ns = 0; ns < 8; ns++) begin
            node_state = 3'(ns);
            rd_status(v);
            check("R10 node status", v, status_exp(3'(ns), 1'b0, 4'h0));
        end
        node_state = 3'b010;

        // R5 disabled flag hidden then R7 per-buffer code sweep
        for (int n = 0; n < 15; n++) begin
            pulse(1'b0, 15'(1 << n));
            settle();
            rd_status(v);
            check("R5 masked", v, status_exp(3'b010, 1'b0, 4'h0));
            wr(2'd1, 16'(1 << n));
            settle();
            rd_status(v);
            check("R7 buffer code", v, status_exp(3'b010, 1'b1, 4'(n + 1)));
            check("R11 irq pin", {15'h0, irq_o}, 16'h1);
            wr(2'd0, ~16'(1 << n));
            settle();
            rd_status(v);
            check("R2 zero bits keep", v, status_exp(3'b010, 1'b1, 4'(n + 1)));
            wr(2'd0, 16'(1 << n));
            settle();
            rd_status(v);
            check("R8 cleared idle", v, status_exp(3'b010, 1'b0, 4'h0));
            wr(2'd1, 16'h0000);
        end

        // R7 lowest buffer wins, all pairs
        wr(2'd1, 16'h7FFF);
        for (int i = 0; i < 15; i++) begin
            for (int j = i + 1; j < 15; j++) begin
                pulse(1'b0, 15'((1 << i) | (1 << j)));
                settle();
                rd_status(v);
                check("R7 lowest wins", v, status_exp(3'b010, 1'b1, 4'(i + 1)));
                wr(2'd0, 16'hFFFF);
            end
        end

        // R6 error outranks buffers, and error alone
        wr(2'd1, 16'hFFFF);
        pulse(1'b1, 15'h7FFF);
        settle();
        rd_status(v);
        check("R6 error first", v, status_exp(3'b010, 1'b1, 4'h0));
        wr(2'd0, 16'h7FFF);
        settle();
        rd_status(v);
        check("R6 error alone", v, status_exp(3'b010, 1'b1, 4'h0));
        wr(2'd1, 16'h7FFF);
        settle();
        rd_status(v);
        check("R5 error masked", v, status_exp(3'b010, 1'b0, 4'h0));
        wr(2'd0, 16'h8000);
        wr(2'd1, 16'hFFFF);
        settle();
        rd_status(v);
        check("R2 error cleared", v, status_exp(3'b010, 1'b0, 4'h0));

        // R9 set and clear in the same cycle
        @(negedge clk);
        buf_set = 15'h0008;
        bus_addr = 2'd0; bus_wdata = 16'h0008; bus_we = 1'b1;
        @(negedge clk);
        buf_set = '0; bus_we = 1'b0;
        settle();
        rd_status(v);
        check("R9 set wins", v, status_exp(3'b010, 1'b1, 4'h4));

        // R10 write to status has no effect
        wr(2'd2, 16'hFFFF);
        bus_addr = 2'd1; #1 check("R10 enable kept", bus_rdata, 16'hFFFF);
        rd_status(v);
        check("R10 status kept", v, status_exp(3'b010, 1'b1, 4'h4));

        // R11 timing: code appears on second edge after a set pulse
        wr(2'd0, 16'hFFFF);
        settle();
        @(negedge clk);
        buf_set = 15'h0001;
        @(negedge clk);
        buf_set = '0;
        check("R11 not yet", {15'h0, irq_o}, 16'h0);
        @(negedge clk);
        check("R11 raised", {15'h0, irq_o}, 16'h1);

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                errors++;
                $display("FAIL watchdog expired got 0 expected 1");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule